// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Tag Lookup

This block is the tag-lookup front end of a level-one cache that picks its set from the virtual address and checks its tags against the physical address. When a request is accepted, the line-offset bits above the byte offset select a set. All of those bits come from the page offset, so they need no translation. In the same cycle, every way's tag and valid bit is copied into a holding register. The virtual page number is also sent out to a translation unit in that cycle. When the translation unit later answers with a physical page number, that number is compared against the held tags. The block then reports hit or miss, the matching way, and which of the four translation/cache outcomes occurred.

A fill port writes a physical page number into one way of one set and marks that way valid. A single invalidate input clears every valid bit. The block handles one lookup at a time. While it waits for the translation, it shows `busy` and ignores new requests. An elaboration check rejects any configuration in which one way (sets × line size) spans more than a page. It also rejects widths and sizes that are not powers of two.

Top module: `vipt_tag_lookup`

## Requirements
- R1: A request with `req_valid` high while `busy` is low raises `tlb_req_valid` in the same cycle, with `tlb_req_vpn` equal to `req_vaddr[31:12]`. `busy` is high from the next cycle on.
- R2: The set is chosen by `req_vaddr[11:6]` only. A physical page number stored in one set does not hit for a lookup whose address selects a neighbouring set.
- R3: The compare uses the tags and valid bits captured in the accept cycle, however many cycles the translation takes. A fill issued after the accept cycle does not change the pending result.
- R4: `res_valid` is high for exactly one cycle: the cycle after the clock edge at which `tlb_rsp_valid` is seen while `busy`. `busy` is low in that same cycle.
- R5: `res_hit` is 1 only when a valid way of the selected set holds a tag equal to `tlb_rsp_ppn`. `res_way` then gives that way's index, and it is 0 on a miss.
- R6: `res_status` is {walked, cache-miss}: 0 = translation hit and cache hit, 1 = translation hit and cache miss, 2 = translation by walk and cache hit, 3 = translation by walk and cache miss. "Walked" is the value of `tlb_rsp_walked`.
- R7: While a lookup waits for its translation, `res_valid` stays low. No hit is declared before the physical page number arrives.
- R8: A fill writes `fill_tag` into way `fill_way` of set `fill_set` and sets that way's valid bit at the next edge. A lookup accepted in the same cycle as the fill still sees the old contents. A lookup accepted later sees the new ones.
- R9: `inval_all` clears every valid bit at the next edge, including the bits held for a pending lookup. It takes priority over a simultaneous fill.
- R10: A request made while `busy` is high produces no `tlb_req_valid` and does not change the pending lookup.
- R11: After reset, `busy`, `res_valid` and every valid bit are 0.
- R12: `tlb_rsp_valid` while `busy` is low produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | VA_W | Virtual address of the lookup |
| busy | output | 1 | A lookup is waiting for its translation |
| tlb_req_valid | output | 1 | Translation request, same cycle as accept |
| tlb_req_vpn | output | VA_W-OFF_W | Virtual page number to translate |
| tlb_rsp_valid | input | 1 | Translation result available |
| tlb_rsp_walked | input | 1 | Translation needed a table walk |
| tlb_rsp_ppn | input | PA_W-OFF_W | Physical page number |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Cache hit |
| res_way | output | WAY_W | Hitting way, 0 on miss |
| res_status | output | 2 | Combined translation/cache outcome |
| fill_en | input | 1 | Write a tag |
| fill_set | input | IDX_W | Set to fill |
| fill_way | input | WAY_W | Way to fill |
| fill_tag | input | PA_W-OFF_W | Physical page number to store |
| inval_all | input | 1 | Clear all valid bits |

## Verification
`tlb_req_valid` and `tlb_req_vpn` are combinational, so they are sampled in the request cycle itself. `busy` is due one edge later. The result fields are registered and appear one edge after the translation response, so they are sampled at the falling edge that follows the response cycle. In every cycle between the accept and the response, the bench checks that `res_valid` is still low. One further cycle after each result, it checks that the strobe has dropped. Fills and invalidates take effect one edge after they are driven, so the bench places a lookup either in that same cycle or after it, depending on which side of the boundary the case exercises.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

   // {walked, cache_miss}
   typedef enum logic [1:0] {
      ST_XLAT_HIT_CACHE_HIT  = 2'b00,
      ST_XLAT_HIT_CACHE_MISS = 2'b01,
      ST_WALK_CACHE_HIT      = 2'b10,
      ST_WALK_CACHE_MISS     = 2'b11
   } lookup_status_e;

   function automatic bit is_pow2(input longint unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
   parameter int SETS  = 64,
   parameter int WAYS  = 4,
   parameter int TAG_W = 20,
   localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fill_en,
   input  logic [IDX_W-1:0]             fill_set,
   input  logic [WAY_W-1:0]             fill_way,
   input  logic [TAG_W-1:0]             fill_tag,
   input  logic                         inval_all,
   input  logic [IDX_W-1:0]             rd_set,
   output logic [WAYS-1:0][TAG_W-1:0]   rd_tags,
   output logic [WAYS-1:0]              rd_valid
);

   logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
   logic [SETS-1:0][WAYS-1:0]  valid_q;

   // tag storage: no reset, guarded by valid bits
   always_ff @(posedge clk) begin
      if (fill_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (fill_way == WAY_W'(w))
               tag_q[fill_set][w] <= fill_tag;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || inval_all)
         valid_q <= '0;
      else if (fill_en)
         valid_q[fill_set][fill_way] <= 1'b1;
   end

   assign rd_tags  = tag_q[rd_set];
   assign rd_valid = valid_q[rd_set];

   p_fill_marks_valid_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !inval_all) |=> valid_q[$past(fill_set)][$past(fill_way)]);

   p_inval_clears_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      inval_all |=> (valid_q == '0));

endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 20,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         check_en,
   input  logic [WAYS-1:0][TAG_W-1:0]   tags,
   input  logic [WAYS-1:0]              valid,
   input  logic [TAG_W-1:0]             ppn,
   output logic                         hit,
   output logic [WAY_W-1:0]             way
);

   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = valid[w] && (tags[w] == ppn);
   end

   always_comb begin
      way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) way = way | WAY_W'(w);
      end
   end

   assign hit = |match;

   p_single_match_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      check_en |-> $onehot0(match));

endmodule

// File: rtl/vipt_tag_lookup.sv
module vipt_tag_lookup #(
   parameter int VA_W       = 32,
   parameter int PA_W       = 32,
   parameter int PAGE_BYTES = 4096,
   parameter int LINE_BYTES = 64,
   parameter int SETS       = 64,
   parameter int WAYS       = 4,
   localparam int OFF_W  = $clog2(PAGE_BYTES),
   localparam int LINE_W = $clog2(LINE_BYTES),
   localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int VPN_W  = VA_W - OFF_W,
   localparam int PPN_W  = PA_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_vaddr,
   output logic               busy,
   output logic               tlb_req_valid,
   output logic [VPN_W-1:0]   tlb_req_vpn,
   input  logic               tlb_rsp_valid,
   input  logic               tlb_rsp_walked,
   input  logic [PPN_W-1:0]   tlb_rsp_ppn,
   output logic               res_valid,
   output logic               res_hit,
   output logic [WAY_W-1:0]   res_way,
   output logic [1:0]         res_status,
   input  logic               fill_en,
   input  logic [IDX_W-1:0]   fill_set,
   input  logic [WAY_W-1:0]   fill_way,
   input  logic [PPN_W-1:0]   fill_tag,
   input  logic               inval_all
);
   import vipt_pkg::*;

   // elaboration checks
   if (!is_pow2(PAGE_BYTES) || !is_pow2(LINE_BYTES) || !is_pow2(SETS) || !is_pow2(WAYS)) begin : g_bad_pow2
      $error("page, line, set and way counts must be powers of two");
   end
   if (SETS * LINE_BYTES > PAGE_BYTES) begin : g_bad_reach
      $error("one way spans more than a page: index would need translated bits");
   end
   if (VA_W <= OFF_W || PA_W <= OFF_W) begin : g_bad_width
      $error("address widths must exceed the page offset");
   end

   logic                       pend_q;
   logic                       accept;
   logic                       resolve;
   logic [IDX_W-1:0]           set_idx;
   logic [WAYS-1:0][PPN_W-1:0] rd_tags;
   logic [WAYS-1:0]            rd_valid;
   logic [WAYS-1:0][PPN_W-1:0] held_tags_q;
   logic [WAYS-1:0]            held_valid_q;
   logic                       cmp_hit;
   logic [WAY_W-1:0]           cmp_way;

   logic                       res_valid_q;
   logic                       res_hit_q;
   logic [WAY_W-1:0]           res_way_q;
   lookup_status_e             res_status_q;

   assign accept  = req_valid && !pend_q;
   assign resolve = pend_q && tlb_rsp_valid;

   // index lies in untranslated bits only
   assign set_idx = req_vaddr[LINE_W +: IDX_W];

   assign tlb_req_valid = accept;
   assign tlb_req_vpn   = req_vaddr[VA_W-1:OFF_W];

   vipt_tag_store #(
      .SETS  (SETS),
      .WAYS  (WAYS),
      .TAG_W (PPN_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_en   (fill_en),
      .fill_set  (fill_set),
      .fill_way  (fill_way),
      .fill_tag  (fill_tag),
      .inval_all (inval_all),
      .rd_set    (set_idx),
      .rd_tags   (rd_tags),
      .rd_valid  (rd_valid)
   );

   // snapshot of the selected set, held across translation latency
   always_ff @(posedge clk) begin
      if (accept) held_tags_q <= rd_tags;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_valid_q <= '0;
      end else if (inval_all) begin
         held_valid_q <= '0;
      end else if (accept) begin
         held_valid_q <= rd_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (accept)  pend_q <= 1'b1;
      else if (resolve) pend_q <= 1'b0;
   end

   vipt_way_match #(
      .WAYS  (WAYS),
      .TAG_W (PPN_W)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .check_en (resolve),
      .tags     (held_tags_q),
      .valid    (held_valid_q),
      .ppn      (tlb_rsp_ppn),
      .hit      (cmp_hit),
      .way      (cmp_way)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid_q  <= 1'b0;
         res_hit_q    <= 1'b0;
         res_way_q    <= '0;
         res_status_q <= ST_XLAT_HIT_CACHE_HIT;
      end else begin
         res_valid_q <= resolve;
         if (resolve) begin
            res_hit_q    <= cmp_hit;
            res_way_q    <= cmp_way;
            res_status_q <= lookup_status_e'({tlb_rsp_walked, !cmp_hit});
         end
      end
   end

   assign busy       = pend_q;
   assign res_valid  = res_valid_q;
   assign res_hit    = res_hit_q;
   assign res_way    = res_way_q;
   assign res_status = res_status_q;

   p_accept_sets_busy_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req_valid |=> busy);

   p_result_due_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tlb_rsp_valid) |=> (res_valid && !busy));

   p_single_pulse_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   p_no_early_result_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(busy && tlb_rsp_valid));

   p_status_agrees_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_status[0] == !res_hit));

   p_miss_way_zero_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_way == '0));

   p_pending_held_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tlb_rsp_valid) |=> (busy && $stable(held_tags_q)));

   p_idle_rsp_dropped_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !tlb_req_valid) |=> !res_valid);

endmodule

// File: tb/vipt_tag_lookup_bench.sv
module vipt_tag_lookup_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        busy;
   logic        tlb_req_valid;
   logic [19:0] tlb_req_vpn;
   logic        tlb_rsp_valid = 1'b0;
   logic        tlb_rsp_walked = 1'b0;
   logic [19:0] tlb_rsp_ppn = '0;
   logic        res_valid;
   logic        res_hit;
   logic [1:0]  res_way;
   logic [1:0]  res_status;
   logic        fill_en = 1'b0;
   logic [5:0]  fill_set = '0;
   logic [1:0]  fill_way = '0;
   logic [19:0] fill_tag = '0;
   logic        inval_all = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vipt_tag_lookup u_vipt_tag_lookup (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .busy(busy),
      .tlb_req_valid(tlb_req_valid), .tlb_req_vpn(tlb_req_vpn),
      .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_walked(tlb_rsp_walked),
      .tlb_rsp_ppn(tlb_rsp_ppn),
      .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
      .res_status(res_status),
      .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
      .fill_tag(fill_tag), .inval_all(inval_all)
   );

   typedef struct packed {
      logic [31:0] va;
      logic [19:0] ppn;
      logic        walked;
      logic [3:0]  dly;
      logic        hit;
      logic [1:0]  way;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{32'hAAAAA140, 20'h12345, 1'b0, 4'd1, 1'b1, 2'd0},
      '{32'h0000117F, 20'h00ABC, 1'b1, 4'd3, 1'b1, 2'd2},
      '{32'h76543148, 20'h00ABD, 1'b0, 4'd2, 1'b0, 2'd0},
      '{32'h11111240, 20'h12345, 1'b1, 4'd1, 1'b1, 2'd3},
      '{32'h22222250, 20'h00ABC, 1'b1, 4'd5, 1'b0, 2'd0},
      '{32'hFFFFFFC0, 20'hFFFFF, 1'b0, 4'd1, 1'b1, 2'd1},
      '{32'h33333040, 20'h00000, 1'b0, 4'd1, 1'b0, 2'd0},
      '{32'h44444000, 20'h00000, 1'b1, 4'd2, 1'b1, 2'd0},
      '{32'h555551BF, 20'h12345, 1'b0, 4'd1, 1'b0, 2'd0}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // all tasks are entered and left just after a falling edge
   task automatic do_fill(input logic [5:0] s, input logic [1:0] w, input logic [19:0] t);
      fill_en = 1'b1; fill_set = s; fill_way = w; fill_tag = t;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic issue(input logic [31:0] va);
      req_valid = 1'b1; req_vaddr = va;
      #1;
      chk(tlb_req_valid == 1'b1, "R1 tlb_req_valid", 64'(tlb_req_valid), 64'd1);
      chk(tlb_req_vpn == va[31:12], "R1/R2 tlb_req_vpn", 64'(tlb_req_vpn), 64'(va[31:12]));
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(busy == 1'b1, "R1 busy after accept", 64'(busy), 64'd1);
   endtask

   task automatic wait_rsp(input int dly);
      for (int i = 1; i < dly; i++) begin
         chk(res_valid == 1'b0, "R7 no result before translation", 64'(res_valid), 64'd0);
         @(negedge clk);
      end
   endtask

   task automatic respond(input logic [19:0] ppn, input logic walked,
                          input logic exp_hit, input logic [1:0] exp_way, input string tag);
      logic [1:0] exp_st;
      exp_st = {walked, !exp_hit};
      tlb_rsp_valid = 1'b1; tlb_rsp_ppn = ppn; tlb_rsp_walked = walked;
      @(negedge clk);
      tlb_rsp_valid = 1'b0;
      #1;
      chk(res_valid == 1'b1, {"R4 res_valid ", tag}, 64'(res_valid), 64'd1);
      chk(busy == 1'b0, {"R4 busy cleared ", tag}, 64'(busy), 64'd0);
      chk(res_hit == exp_hit, {"R5 res_hit ", tag}, 64'(res_hit), 64'(exp_hit));
      chk(res_way == exp_way, {"R5 res_way ", tag}, 64'(res_way), 64'(exp_way));
      chk(res_status == exp_st, {"R6 res_status ", tag}, 64'(res_status), 64'(exp_st));
      @(negedge clk);
      #1;
      chk(res_valid == 1'b0, {"R4 single pulse ", tag}, 64'(res_valid), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(busy == 1'b0, "R11 busy at reset", 64'(busy), 64'd0);
      chk(res_valid == 1'b0, "R11 res_valid at reset", 64'(res_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: valid bits clear after reset, tag 0 must not hit
      issue(32'h33333000);
      respond(20'h00000, 1'b0, 1'b0, 2'd0, "R11 empty set");

      do_fill(6'd5, 2'd0, 20'h12345);
      do_fill(6'd5, 2'd2, 20'h00ABC);
      do_fill(6'd9, 2'd3, 20'h12345);
      do_fill(6'd63, 2'd1, 20'hFFFFF);
      do_fill(6'd0, 2'd0, 20'h00000);

      // R2 R5 R6 R7: table walk
      for (int v = 0; v < NV; v++) begin
         issue(VECS[v].va);
         wait_rsp(int'(VECS[v].dly));
         respond(VECS[v].ppn, VECS[v].walked, VECS[v].hit, VECS[v].way, $sformatf("vec%0d", v));
      end

      // R3: fill during a pending lookup does not change it
      issue(32'h00000500);
      do_fill(6'd20, 2'd1, 20'h55555);
      wait_rsp(3);
      respond(20'h55555, 1'b0, 1'b0, 2'd0, "R3 snapshot");
      issue(32'h00000500);
      respond(20'h55555, 1'b0, 1'b1, 2'd1, "R3 after fill");

      // R8: same-cycle fill is not seen, next lookup is
      fill_en = 1'b1; fill_set = 6'd30; fill_way = 2'd2; fill_tag = 20'h00777;
      issue(32'h99999780);
      fill_en = 1'b0;
      respond(20'h00777, 1'b1, 1'b0, 2'd0, "R8 same cycle");
      issue(32'h99999780);
      respond(20'h00777, 1'b1, 1'b1, 2'd2, "R8 later");

      // R10: request while busy is ignored
      issue(32'hAAAAA140);
      req_valid = 1'b1; req_vaddr = 32'h11111240;
      #1;
      chk(tlb_req_valid == 1'b0, "R10 no translation while busy", 64'(tlb_req_valid), 64'd0);
      @(negedge clk);
      req_valid = 1'b0;
      respond(20'h12345, 1'b0, 1'b1, 2'd0, "R10 original kept");

      // R12: response while idle
      tlb_rsp_valid = 1'b1; tlb_rsp_ppn = 20'h12345;
      @(negedge clk);
      tlb_rsp_valid = 1'b0;
      #1;
      chk(res_valid == 1'b0, "R12 idle response ignored", 64'(res_valid), 64'd0);
      chk(busy == 1'b0, "R12 still idle", 64'(busy), 64'd0);
      @(negedge clk);

      // R9: invalidate clears pending snapshot and the array
      issue(32'hAAAAA140);
      inval_all = 1'b1;
      @(negedge clk);
      inval_all = 1'b0;
      respond(20'h12345, 1'b0, 1'b0, 2'd0, "R9 pending cleared");
      issue(32'hFFFFFFC0);
      respond(20'hFFFFF, 1'b0, 1'b0, 2'd0, "R9 array cleared");

      // R9: invalidate wins over a simultaneous fill
      fill_en = 1'b1; fill_set = 6'd7; fill_way = 2'd3; fill_tag = 20'h0BEEF;
      inval_all = 1'b1;
      @(negedge clk);
      fill_en = 1'b0; inval_all = 1'b0;
      issue(32'h000001C0);
      respond(20'h0BEEF, 1'b0, 1'b0, 2'd0, "R9 priority");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule